// File: doc/BRIEF.md
# Programmable External Interrupt Sense Controller

This block watches eight external interrupt request pins and turns each one into an internal request line. Software gives every pin a 2-bit sense mode. The mode selects low-level sensing, falling-edge detection, rising-edge detection or detection on both edges. Each pin input passes through a two-stage synchronizer first. Edges are then found by comparing the synchronized value with a copy delayed by one cycle.

In the edge modes a detected edge sets a sticky per-pin flag. The flag holds until software clears it. In low-level mode the request simply follows the inverted synchronized pin.

Software reaches the block over a plain synchronous register bus. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The bus has no handshake and cannot stall.

Top module: `irq_sense_ctrl`

## Requirements
- R1: After reset, both mode registers and the flag register read 0x00. With all pins held high, `irq_req` is 0.
- R2: Address 0 holds the modes of pins 7..4 and address 1 holds the modes of pins 3..0. Within each register, pin 4k+j uses bits 2j+1:2j, with the B bit upper and the A bit lower. Every bit reads back what was last written.
- R3: In mode 00 (low level), `irq_req[n]` is 1 while pin n is low and 0 while it is high. It updates by the third rising clock edge after the pin changes, and no sticky flag is ever set.
- R4: In mode 01 (falling edge), a high-to-low transition sets flag n, and `irq_req[n]` stays 1 after the pin returns high. A rising transition alone sets nothing.
- R5: In mode 10 (rising edge), a low-to-high transition sets flag n. A falling transition alone sets nothing.
- R6: In mode 11 (both edges), either transition sets flag n.
- R7: Writing address 2 clears every flag whose data bit is 1 and leaves flags whose bit is 0 unchanged. Reading address 2 returns the flags, bit n for pin n.
- R8: If an edge is detected in the same cycle as a clear of that pin's flag, the flag stays set.
- R9: A write that changes a pin's mode field clears that pin's flag. Rewriting the same value keeps the flag. A mode change never creates an edge of its own, even while the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 upper modes, 1 lower modes, 2 flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ext_irq | input | 8 | Asynchronous external interrupt pins |
| irq_req | output | 8 | Per-pin interrupt request |

## Verification
Most wrong internal states show up on `irq_req` within three clock edges:

- A misplaced mode field makes the wrong pin react, or react to the wrong edge polarity.
- A stuck or lost flag shows as a request that persists after a clear, or one that never appears.
- Corrupted edge history shows as a spurious request right after a mode write made while the pin is low.

Flag state is also visible at once on a read of address 2. The sweep therefore covers every pin in every mode with both transitions, then probes the clear/edge collision and mode rewrites at exact cycles.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_FALL = 2'b01,
    SNS_RISE = 2'b10,
    SNS_BOTH = 2'b11
  } sense_t;

  localparam logic [1:0] ADDR_HI  = 2'd0;
  localparam logic [1:0] ADDR_LO  = 2'd1;
  localparam logic [1:0] ADDR_FLG = 2'd2;
endpackage

// File: rtl/isc_sync.sv
module isc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '1;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/isc_regs.sv
module isc_regs import isc_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic [1:0]            bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [DATA_W-1:0]     flags,
  output logic [2*DATA_W-1:0]   mode_vec,
  output logic [DATA_W-1:0]     mode_chg,
  output logic [DATA_W-1:0]     clr
);
  localparam int NPINS    = DATA_W;
  localparam int PER_REG  = DATA_W / 2;

  logic [DATA_W-1:0] mode_hi, mode_lo;
  logic              wr_hi, wr_lo;

  assign wr_hi = bus_wr && (bus_addr == ADDR_HI);
  assign wr_lo = bus_wr && (bus_addr == ADDR_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_hi <= '0;
      mode_lo <= '0;
    end else begin
      if (wr_hi) mode_hi <= bus_wdata;
      if (wr_lo) mode_lo <= bus_wdata;
    end
  end

  assign mode_vec = {mode_hi, mode_lo};

  for (genvar n = 0; n < NPINS; n++) begin : g_chg
    if (n >= PER_REG) begin : g_up
      assign mode_chg[n] = wr_hi &&
        (bus_wdata[2*(n-PER_REG) +: 2] != mode_hi[2*(n-PER_REG) +: 2]);
    end else begin : g_dn
      assign mode_chg[n] = wr_lo &&
        (bus_wdata[2*n +: 2] != mode_lo[2*n +: 2]);
    end
  end

  assign clr = (bus_wr && (bus_addr == ADDR_FLG)) ? bus_wdata : '0;

  always_comb begin
    case (bus_addr)
      ADDR_HI:  bus_rdata = mode_hi;
      ADDR_LO:  bus_rdata = mode_lo;
      ADDR_FLG: bus_rdata = flags;
      default:  bus_rdata = '0;
    endcase
  end

  a_r2_hi_readback: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> (mode_vec[2*DATA_W-1:DATA_W] == $past(bus_wdata)));
  a_r2_lo_keeps_hi: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr != ADDR_HI) |=> $stable(mode_vec[2*DATA_W-1:DATA_W]));
endmodule

// File: rtl/isc_pin.sv
module isc_pin import isc_pkg::*; (
  input  logic   clk,
  input  logic   rst,
  input  logic   pin_s,
  input  sense_t mode,
  input  logic   mode_chg,
  input  logic   clr,
  output logic   flag,
  output logic   req
);
  logic prev, fall, rise, hit;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= pin_s;
  end

  assign fall = prev & ~pin_s;
  assign rise = ~prev & pin_s;

  always_comb begin
    case (mode)
      SNS_FALL: hit = fall;
      SNS_RISE: hit = rise;
      SNS_BOTH: hit = fall | rise;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (mode_chg) flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  assign req = (mode == SNS_LOW) ? ~pin_s : flag;

  a_r3_level_no_flag: assert property (@(posedge clk) disable iff (rst)
    (mode == SNS_LOW) |-> !flag);
  a_r9_change_clears: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !flag);
  a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (hit && clr && !mode_chg) |=> flag);
  a_r4_flag_needs_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(hit));
endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl import isc_pkg::*; #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] ext_irq,
  output logic [DATA_W-1:0] irq_req
);
  localparam int NPINS = DATA_W;

  logic [NPINS-1:0]   pin_s, flags, mode_chg, clr;
  logic [2*NPINS-1:0] mode_vec;

  isc_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(ext_irq), .q(pin_s)
  );

  isc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flags(flags),
    .mode_vec(mode_vec), .mode_chg(mode_chg), .clr(clr)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    isc_pin u_pin (
      .clk(clk), .rst(rst), .pin_s(pin_s[n]),
      .mode(sense_t'(mode_vec[2*n +: 2])),
      .mode_chg(mode_chg[n]), .clr(clr[n]),
      .flag(flags[n]), .req(irq_req[n])
    );
  end
endmodule

// File: tb/sim_irq_sense_ctrl.sv
module sim_irq_sense_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, ext_irq, irq_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  irq_sense_ctrl u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_irq(ext_irq), .irq_req(irq_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_check(input string tag, input logic [1:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h0, 8'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] fa;
    logic [7:0] bit_p, exp_fall, exp_rise;
    logic [7:0] pats [6];
    string      tag;

    rst = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00; ext_irq = 8'hFF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    read_check("R1 mode_hi", 2'd0, 8'h00);
    read_check("R1 mode_lo", 2'd1, 8'h00);
    read_check("R1 flags",   2'd2, 8'h00);
    check("R1 irq_req", irq_req, 8'h00);

    // R2 readback of every bit
    pats = '{8'hFF, 8'hA5, 8'h5A, 8'h3C, 8'hC3, 8'h00};
    foreach (pats[i]) begin
      reg_write(2'd0, pats[i]);
      reg_write(2'd1, ~pats[i]);
      read_check("R2 hi readback", 2'd0, pats[i]);
      read_check("R2 lo readback", 2'd1, ~pats[i]);
    end
    settle();
    check("R2 no request after mode writes", irq_req, 8'h00);

    // Sweep every pin in every mode through both transitions
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 4; m++) begin
        bit_p = 8'h01 << p;
        fa    = (p >= 4) ? 2'd0 : 2'd1;
        case (m)
          0: tag = "R3";
          1: tag = "R4";
          2: tag = "R5";
          default: tag = "R6";
        endcase
        exp_fall = (m == 2) ? 8'h00 : bit_p;
        exp_rise = (m == 0) ? 8'h00 : bit_p;

        reg_write(fa, 8'(m) << (2 * (p % 4)));
        reg_write(2'd2, 8'hFF);
        settle();

        @(negedge clk); ext_irq = ~bit_p;
        settle();
        check({tag, " after fall"}, irq_req, exp_fall);

        @(negedge clk); ext_irq = 8'hFF;
        settle();
        check({tag, " after rise"}, irq_req, exp_rise);
        read_check({tag, " flag read"}, 2'd2, exp_rise);

        if (m != 0) begin
          reg_write(2'd2, ~bit_p);
          check("R7 zero bits keep flag", irq_req, bit_p);
          reg_write(2'd2, bit_p);
          check("R7 one bit clears flag", irq_req, 8'h00);
          read_check("R7 flags after clear", 2'd2, 8'h00);
        end

        reg_write(fa, 8'h00);
      end
    end

    // R8: edge coinciding with clear keeps the flag (pin 2, falling mode)
    reg_write(2'd1, 8'h10);
    settle();
    @(negedge clk); ext_irq = 8'hFB;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h04;
    @(negedge clk); bus_wr = 1'b0;
    settle();
    check("R8 edge wins over clear", irq_req, 8'h04);
    read_check("R8 flag read", 2'd2, 8'h04);

    // Clear one cycle after the edge does clear it
    @(negedge clk); ext_irq = 8'hFF;
    settle();
    reg_write(2'd2, 8'h04);
    @(negedge clk); ext_irq = 8'hFB;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h04;
    @(negedge clk); bus_wr = 1'b0;
    check("R7 clear after edge", irq_req, 8'h00);

    // R9: same-value rewrite keeps flag; change clears it
    @(negedge clk); ext_irq = 8'hFF;
    settle();
    @(negedge clk); ext_irq = 8'hFB;
    settle();
    check("R9 flag set before rewrite", irq_req, 8'h04);
    reg_write(2'd1, 8'h10);
    settle();
    check("R9 same value keeps flag", irq_req, 8'h04);
    reg_write(2'd1, 8'h30);
    settle();
    check("R9 change clears flag", irq_req, 8'h00);
    read_check("R9 flags read", 2'd2, 8'h00);

    // R9: mode change while pin low creates no edge
    reg_write(2'd1, 8'h00);
    settle();
    check("R3 level request pin low", irq_req, 8'h04);
    reg_write(2'd1, 8'h10);
    settle();
    check("R9 no false edge on change", irq_req, 8'h00);
    reg_write(2'd1, 8'h30);
    settle();
    check("R9 no false edge both mode", irq_req, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule